// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block sits between seven external interrupt request sources and an 8051-style processor core. Each request passes through a two-stage synchronizer and then an edge detector. A detected edge sets the flag of its line. The line's enable bit then gates that flag onto a pending output. Priority resolution and vectoring happen in the core. The core pulses the acknowledge bit of a line when it vectors to that line.

Lines 0 and 1 trigger on falling edges. Lines 2 and 3 each have a polarity bit that selects the trigger edge. Line 5 is fed by its source inverted, so a falling source edge triggers it. Lines 4 and 6 each merge three event sources, and every source has its own flag and enable bit. The merged request of a line is high while any enabled source flag is set. The line flag is set on the rising edge of that merged request.

There are two ways to clear a flag. An acknowledge clears the flag of lines 0 to 5. Software can clear any flag by writing a mask with a zero at that bit. Ones in the mask leave flags alone, so one bit can be cleared without disturbing others that become pending at the same time.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_pend_o` is zero. Registers are at these addresses: 0 line enables [6:0], 1 line flags [6:0], 2 polarity (bit 0 line 2, bit 1 line 3), 3 source enables, 4 source flags. In the source registers, bits [2:0] belong to line 4 sources 0..2 and bits [5:3] to line 6 sources 0..2. Unused bits and addresses read zero.
- R2: A falling edge on `ext_raw_i[0]` or `ext_raw_i[1]` sets the line flag on the third rising clock edge after the change. A level that stays low does not set the flag again.
- R3: Lines 2 and 3 set their flag on a rising edge when their polarity bit is 1 and on a falling edge when it is 0. Edges of the other direction are ignored.
- R4: Line 5 sets its flag on a falling edge of `l5_raw_i` and ignores rising edges.
- R5: `irq_pend_o[i]` is high exactly when line flag i and line enable i are both set. Clearing an enable hides the flag but does not clear it.
- R6: An acknowledge pulse on `ack_i[i]` clears line flag i on the next edge for lines 0 to 5. An acknowledge on line 6 has no effect.
- R7: A write to the line flag register clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R8: A rising edge on a source input sets its source flag after the same three-edge latency as R2. Acknowledging line 4 leaves the line 4 source flags unchanged.
- R9: A write to the source flag register clears each source flag whose data bit is 0 and ignores data bits that are 1.
- R10: The merged request of line 4 or line 6 is the OR of its source flags ANDed with their enables. The line flag is set only when that merged request rises, so it is not set again while some enabled source flag stays set. Re-enabling a source whose flag is still set raises the request again.
- R11: When a set event and a clear (software write or acknowledge) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_raw_i | input | 4 | Raw requests for lines 0..3 |
| l5_raw_i | input | 1 | Raw request for line 5, active on its falling edge |
| l4_src_i | input | 3 | Event sources merged into line 4 |
| l6_src_i | input | 3 | Event sources merged into line 6 |
| ack_i | input | 7 | Per-line vector acknowledge pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| irq_pend_o | output | 7 | Enabled pending requests per line |

## Verification
A flag can be set in the same cycle that it is cleared. This happens either when a clear-by-zero write lands on the edge that latches a new source event, or when an acknowledge lands on the edge that latches a new line edge. The bench changes the input at a falling clock edge. It then places the write or the acknowledge exactly two cycles later, so both reach the flag register on the third rising edge. The result passes only if the new flag stays set while the bystander flags cleared by the same write are gone.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_LINES = 7;
  localparam int NUM_DIRECT = 5;  // lines 0,1,2,3,5
  localparam int SUB_PER_GRP = 3;
  localparam int NUM_GRP = 2;     // lines 4 and 6
  localparam int NUM_SUB = SUB_PER_GRP * NUM_GRP;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;
  localparam int SYNC_STAGES = 2;

  // lines whose flag is cleared by the vector acknowledge
  localparam logic [NUM_LINES-1:0] AUTO_CLR_MASK = 7'b011_1111;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LINE_EN  = 3'd0,
    ADDR_LINE_FLG = 3'd1,
    ADDR_POL      = 3'd2,
    ADDR_SUB_EN   = 3'd3,
    ADDR_SUB_FLG  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] rise_sel_i,  // 1: rising, 0: falling
  output logic [W-1:0] edge_o
);
  logic [W-1:0] sync_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = (rise_sel_i & sync_q[STAGES-1] & ~prev_q) |
                  (~rise_sel_i & ~sync_q[STAGES-1] & prev_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           ext_raw_i,
  input  logic                 l5_raw_i,
  input  logic [2:0]           l4_src_i,
  input  logic [2:0]           l6_src_i,
  input  logic [NUM_LINES-1:0] ack_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_pend_o
);
  logic [NUM_LINES-1:0] line_en;
  logic [1:0]           pol_q;
  logic [NUM_SUB-1:0]   sub_en;
  logic [NUM_LINES-1:0] line_flag, line_set, line_clr;
  logic [NUM_SUB-1:0]   sub_flag, sub_set, sub_clr;
  logic [NUM_DIRECT-1:0] dir_edge, dir_raw, dir_rise;
  logic [NUM_GRP-1:0]   grp_req, grp_q, grp_rise;
  logic                 wr_line_flg, wr_sub_flg;
  logic                 unused_wdata;

  assign unused_wdata = reg_wdata_i[REG_W-1];

  // direct lines: order {5,3,2,1,0}; line 5 inverted so its falling edge counts
  assign dir_raw  = {~l5_raw_i, ext_raw_i};
  assign dir_rise = {1'b1, pol_q, 2'b00};

  irq_edge_det #(.W(NUM_DIRECT), .STAGES(SYNC_STAGES)) u_dir_edge (
    .clk_i, .rst_ni, .raw_i(dir_raw), .rise_sel_i(dir_rise), .edge_o(dir_edge)
  );

  irq_edge_det #(.W(NUM_SUB), .STAGES(SYNC_STAGES)) u_sub_edge (
    .clk_i, .rst_ni, .raw_i({l6_src_i, l4_src_i}), .rise_sel_i({NUM_SUB{1'b1}}),
    .edge_o(sub_set)
  );

  assign wr_sub_flg  = reg_we_i && (reg_addr_i == ADDR_SUB_FLG);
  assign wr_line_flg = reg_we_i && (reg_addr_i == ADDR_LINE_FLG);

  assign sub_clr = wr_sub_flg ? ~reg_wdata_i[NUM_SUB-1:0] : '0;

  irq_flag_bank #(.W(NUM_SUB)) u_sub_flags (
    .clk_i, .rst_ni, .set_i(sub_set), .clr_i(sub_clr), .flag_o(sub_flag)
  );

  // merged request per group, line flag on its rising edge
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_req[g] = |(sub_flag[g*SUB_PER_GRP +: SUB_PER_GRP] &
                          sub_en[g*SUB_PER_GRP +: SUB_PER_GRP]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_q <= '0;
    else         grp_q <= grp_req;
  end
  assign grp_rise = grp_req & ~grp_q;

  assign line_set = {grp_rise[1], dir_edge[4], grp_rise[0], dir_edge[3:0]};
  assign line_clr = (wr_line_flg ? ~reg_wdata_i[NUM_LINES-1:0] : '0) |
                    (ack_i & AUTO_CLR_MASK);

  irq_flag_bank #(.W(NUM_LINES)) u_line_flags (
    .clk_i, .rst_ni, .set_i(line_set), .clr_i(line_clr), .flag_o(line_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_en <= '0;
      pol_q   <= '0;
      sub_en  <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        ADDR_LINE_EN: line_en <= reg_wdata_i[NUM_LINES-1:0];
        ADDR_POL:     pol_q   <= reg_wdata_i[1:0];
        ADDR_SUB_EN:  sub_en  <= reg_wdata_i[NUM_SUB-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_LINE_EN:  reg_rdata_o[NUM_LINES-1:0] = line_en;
      ADDR_LINE_FLG: reg_rdata_o[NUM_LINES-1:0] = line_flag;
      ADDR_POL:      reg_rdata_o[1:0]           = pol_q;
      ADDR_SUB_EN:   reg_rdata_o[NUM_SUB-1:0]   = sub_en;
      ADDR_SUB_FLG:  reg_rdata_o[NUM_SUB-1:0]   = sub_flag;
      default: ;
    endcase
  end

  assign irq_pend_o = line_flag & line_en;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] ack_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [NUM_LINES-1:0] line_flag,
  input logic [NUM_LINES-1:0] line_set,
  input logic [NUM_SUB-1:0]   sub_flag,
  input logic [NUM_SUB-1:0]   sub_set
);
  for (genvar i = 0; i < NUM_LINES - 1; i++) begin : g_ack
    assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[i] && !line_set[i] |=> !line_flag[i]);
  end

  assert_l6_ack_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i[6] && line_flag[6] &&
    !(reg_we_i && reg_addr_i == ADDR_LINE_FLG && !reg_wdata_i[6]) |=> line_flag[6]);

  assert_flag_ones_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == ADDR_LINE_FLG && reg_wdata_i[NUM_LINES-1:0] == '1 &&
    (ack_i & AUTO_CLR_MASK) == '0
    |=> (line_flag & $past(line_flag)) == $past(line_flag));

  assert_sub_ones_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == ADDR_SUB_FLG && reg_wdata_i[NUM_SUB-1:0] == '1
    |=> (sub_flag & $past(sub_flag)) == $past(sub_flag));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lset
    assert_line_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_set[i] |=> line_flag[i]);
  end

  for (genvar j = 0; j < NUM_SUB; j++) begin : g_sset
    assert_sub_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sub_set[j] |=> sub_flag[j]);
  end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .line_flag(line_flag),
  .line_set(line_set), .sub_flag(sub_flag), .sub_set(sub_set)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ext_raw_i = 4'hF;
  logic       l5_raw_i = 1'b1;
  logic [2:0] l4_src_i = '0;
  logic [2:0] l6_src_i = '0;
  logic [6:0] ack_i = '0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [6:0] irq_pend_o;

  localparam logic [2:0] PEND = 3'd7;  // pseudo address: compare irq_pend_o

  typedef struct {
    logic [2:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always #5 clk_i = ~clk_i;

  ext_irq_ctrl dut_i (.*);

  // monitor: pops expectations and compares against outputs
  initial forever begin
    @(chk_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = (it.addr == PEND) ? {1'b0, irq_pend_o} : reg_rdata_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: addr %0d actual 0x%02h expected 0x%02h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic expect_val(input logic [2:0] addr, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk_i);
    reg_addr_i = (addr == PEND) ? 3'd0 : addr;
    it.addr = addr; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->chk_ev;
    #2;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = addr; reg_wdata_i = data;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic ack(input logic [6:0] m);
    @(negedge clk_i);
    ack_i = m;
    @(negedge clk_i);
    ack_i = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(3);
    // R1 reset state
    for (int a = 0; a < 5; a++) expect_val(3'(a), 8'h00, "R1 reset reg");
    expect_val(PEND, 8'h00, "R1 reset pend");

    wr(3'd0, 8'h7F);
    expect_val(3'd0, 8'h7F, "R1 enable readback");

    // R2 line 0 falling edge, R6 ack
    @(negedge clk_i) ext_raw_i[0] = 1'b0;
    cyc(4);
    expect_val(3'd1, 8'h01, "R2 line0 fall");
    expect_val(PEND, 8'h01, "R5 line0 pend");
    ack(7'h01);
    expect_val(3'd1, 8'h00, "R6 ack line0");

    // R5 gating by enable
    @(negedge clk_i) ext_raw_i[0] = 1'b1;
    cyc(4);
    expect_val(3'd1, 8'h00, "R2 rising ignored line0");
    wr(3'd0, 8'h7E);
    @(negedge clk_i) ext_raw_i[0] = 1'b0;
    cyc(4);
    expect_val(3'd1, 8'h01, "R5 flag set while disabled");
    expect_val(PEND, 8'h00, "R5 disabled hides");
    wr(3'd0, 8'h7F);
    expect_val(PEND, 8'h01, "R5 re-enable shows");
    wr(3'd1, 8'hFE);
    expect_val(3'd1, 8'h00, "R7 write zero clears");

    // R2 held level, R7
    @(negedge clk_i) ext_raw_i[1] = 1'b0;
    cyc(4);
    expect_val(3'd1, 8'h02, "R2 line1 fall");
    wr(3'd1, 8'hFD);
    cyc(4);
    expect_val(3'd1, 8'h00, "R2 held low no retrigger");

    // R3 polarity
    wr(3'd2, 8'h01);
    expect_val(3'd2, 8'h01, "R3 pol readback");
    @(negedge clk_i) ext_raw_i[2] = 1'b0;
    cyc(4);
    expect_val(3'd1, 8'h00, "R3 line2 falling ignored");
    @(negedge clk_i) ext_raw_i[2] = 1'b1;
    cyc(4);
    expect_val(3'd1, 8'h04, "R3 line2 rising");
    @(negedge clk_i) ext_raw_i[3] = 1'b0;
    cyc(4);
    expect_val(3'd1, 8'h0C, "R3 line3 falling");
    ack(7'h0C);
    expect_val(3'd1, 8'h00, "R6 ack lines2,3");

    // R4 line 5
    @(negedge clk_i) l5_raw_i = 1'b0;
    cyc(4);
    expect_val(3'd1, 8'h20, "R4 line5 fall");
    ack(7'h20);
    @(negedge clk_i) l5_raw_i = 1'b1;
    cyc(4);
    expect_val(3'd1, 8'h00, "R4 line5 rise ignored");

    // R8 line 4 sources, R9
    wr(3'd3, 8'h3F);
    @(negedge clk_i) l4_src_i[1] = 1'b1;
    cyc(5);
    expect_val(3'd4, 8'h02, "R8 src flag");
    expect_val(3'd1, 8'h10, "R10 line4 flag");
    expect_val(PEND, 8'h10, "R10 line4 pend");
    ack(7'h10);
    expect_val(3'd1, 8'h00, "R6 ack line4");
    expect_val(3'd4, 8'h02, "R8 ack keeps src flag");
    wr(3'd4, 8'hFF);
    expect_val(3'd4, 8'h02, "R9 ones ignored");
    wr(3'd4, 8'hFD);
    expect_val(3'd4, 8'h00, "R9 zero clears");

    // R6 line 6 manual, R10 merge
    @(negedge clk_i) l6_src_i[0] = 1'b1;
    cyc(5);
    expect_val(3'd4, 8'h08, "R8 line6 src0");
    expect_val(3'd1, 8'h40, "R10 line6 flag");
    ack(7'h40);
    expect_val(3'd1, 8'h40, "R6 line6 ack ignored");
    wr(3'd1, 8'hBF);
    expect_val(3'd1, 8'h00, "R7 line6 clear");
    @(negedge clk_i) l6_src_i[2] = 1'b1;
    cyc(5);
    expect_val(3'd4, 8'h28, "R8 line6 src2");
    expect_val(3'd1, 8'h00, "R10 no retrigger while high");
    wr(3'd4, 8'hF7);
    cyc(2);
    expect_val(3'd4, 8'h20, "R9 single clear");
    expect_val(3'd1, 8'h00, "R10 still high no set");
    wr(3'd4, 8'hDF);
    cyc(2);
    @(negedge clk_i) l6_src_i[1] = 1'b1;
    cyc(5);
    expect_val(3'd1, 8'h40, "R10 new rise sets line6");
    wr(3'd3, 8'h2F);
    wr(3'd1, 8'hBF);
    cyc(3);
    expect_val(3'd1, 8'h00, "R10 disabled src no set");
    wr(3'd3, 8'h3F);
    cyc(2);
    expect_val(3'd1, 8'h40, "R10 re-enable raises line6");
    wr(3'd1, 8'hBF);

    // R11 source set vs software clear
    @(negedge clk_i) l4_src_i[2] = 1'b1;
    cyc(5);
    expect_val(3'd4, 8'h14, "R8 line4 src2");
    ack(7'h10);
    @(negedge clk_i) l4_src_i[0] = 1'b1;
    cyc(2);
    reg_we_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 8'h00;
    @(negedge clk_i) reg_we_i = 1'b0;
    expect_val(3'd4, 8'h01, "R11 src set beats clear");
    expect_val(3'd1, 8'h00, "R10 line4 stays without new rise");

    // R11 line set vs ack
    @(negedge clk_i) ext_raw_i[0] = 1'b1;
    cyc(4);
    @(negedge clk_i) ext_raw_i[0] = 1'b0;
    cyc(2);
    ack_i = 7'h01;
    @(negedge clk_i) ack_i = '0;
    expect_val(3'd1, 8'h01, "R11 line set beats ack");
    expect_val(PEND, 8'h01, "R11 pend after collision");

    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule